// File: doc/BRIEF.md
# Clock Output Enable Controller

This block is the digital control core of a two-output clock fan-out buffer. It decides, cycle by cycle, whether each differential output carries the reference clock or rests at a programmed idle level. It also picks the PLL operating mode and fixes the device's bus address. The output stage is modelled as a pair of gated logic signals per output: a true signal and a complement signal.

An output runs only when four things hold at once. The power-good input is high. The output's register enable bit is 1. Its active-low enable pin is 0. The PLL is locked, unless the device is in bypass mode, where the PLL is off and the outputs follow the reference directly. The enable pins and the lock flag arrive asynchronously, so each passes through a two-flop synchroniser. The gating of an output changes only while the reference is low, so no shortened pulses reach the outputs.

Two tri-level straps, each presented as a 2-bit level code, set the behaviour at power-up. The address strap is captured once, on the first power-good event after reset. The mode strap selects the PLL mode unless a register override is set. A small register port gives access to the enable bits, the mode control and the idle-level field, and reads back the strap mode and the captured address. All registers reset to values that let the device run with no bus traffic at all.

Top module: `clkbuf_oe_ctrl`

## Requirements
- R1: While `pwr_good` is 0, every `dif_p` and `dif_n` bit is 0 and `pll_en` is 0, in the same cycle and whatever the other inputs are.
- R2: Output i carries the clock only when register enable bit i is 1 and `oe_pin_n[i]` is 0. Any other combination parks that output at its idle level. The pin passes through a two-flop synchroniser.
- R3: A parked output drives `dif_p` at the level of idle field bit 0 and `dif_n` at the level of idle field bit 1. The idle field is bits [1:0] of register address 1.
- R4: When `pll_mode` is not bypass, every output stays parked until the synchronised `pll_lock` is 1.
- R5: The mode level code maps 00 to low bandwidth (`pll_mode` 00), 01 or 10 to bypass (01) and 11 to high bandwidth (11). In bypass, `pll_en` is 0 and the outputs run without lock. In the other two modes, `pll_en` equals `pwr_good`.
- R6: Reading address 2 returns the strap mode code in bits [1:0], and writes to addresses 2 and 3 are ignored. At address 0, bits [1:0] hold the enables, bits [3:2] the mode control and bit 4 the override. When the override is 1, the mode control drives `pll_mode`, with 10 read as bypass.
- R7: `bus_addr` is 0 until the first cycle in which the synchronised `pwr_good` is 1. At that point it latches 1101011 (level 00), 1101100 (level 01 or 10) or 1101101 (level 11) from `addr_lvl`, and it never changes again until reset.
- R8: While running, `dif_p` equals `ref_in` sampled at the previous clock edge and `dif_n` is its inverse. The gate of an output is updated only at edges where `ref_in` is 0.
- R9: After reset, address 0 reads 0x03, address 1 reads 0x00, and address 3 reads 0x00 until the address is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power good (1) or power down (0) |
| oe_pin_n | input | 2 | Active-low per-output enable pins |
| addr_lvl | input | 2 | Address strap level code |
| mode_lvl | input | 2 | PLL mode strap level code |
| pll_lock | input | 1 | PLL lock indication, asynchronous |
| ref_in | input | 1 | Reference clock level, sampled by clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| bus_addr | output | 7 | Captured bus address |
| pll_mode | output | 2 | Effective PLL mode code |
| pll_en | output | 1 | PLL power enable |
| dif_p | output | 2 | True output signals |
| dif_n | output | 2 | Complement output signals |

## Verification
The assertions assume that the straps hold a 2-bit level code and that power-down is the only thing that forces the outputs low outside the idle field. They also assume that no legal captured address is zero, so a non-zero `bus_addr` marks the latched state. The stimulus keeps `reg_we` to single-cycle strobes with stable address and data, changes the straps and pins only between edges, and drives `ref_in` as a slow square wave with a six-cycle period. Because of that waveform, every gate update sees a reference-low edge within three cycles.

// File: rtl/clkbuf_pkg.sv
package clkbuf_pkg;

    typedef enum logic [1:0] {
        PLL_LO_BW  = 2'b00,
        PLL_BYPASS = 2'b01,
        PLL_HI_BW  = 2'b11
    } pll_mode_e;

    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] BUS_ADDR_LVL_LO  = 7'b1101011;
    localparam logic [ADDR_W-1:0] BUS_ADDR_LVL_MID = 7'b1101100;
    localparam logic [ADDR_W-1:0] BUS_ADDR_LVL_HI  = 7'b1101101;

    localparam int RA_CTRL    = 0;
    localparam int RA_IDLE    = 1;
    localparam int RA_MODE_RB = 2;
    localparam int RA_ADDR_RB = 3;

    function automatic pll_mode_e level_to_mode(input logic [1:0] lvl);
        case (lvl)
            2'b00:   return PLL_LO_BW;
            2'b11:   return PLL_HI_BW;
            default: return PLL_BYPASS;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] level_to_addr(input logic [1:0] lvl);
        case (lvl)
            2'b00:   return BUS_ADDR_LVL_LO;
            2'b11:   return BUS_ADDR_LVL_HI;
            default: return BUS_ADDR_LVL_MID;
        endcase
    endfunction

endpackage

// File: rtl/clkbuf_sync.sv
module clkbuf_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d_in;
        for (int k = 1; k < STAGES; k++) begin
            st_d[k] = st_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                st_q[k] <= RST_VAL;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign q_out = st_q[STAGES-1];

endmodule

// File: rtl/clkbuf_regs.sv
module clkbuf_regs
    import clkbuf_pkg::*;
#(
    parameter int N_OUT = 2,
    parameter int DW    = 8,
    parameter int AW    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  pll_mode_e         strap_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [N_OUT-1:0]  out_en,
    output logic [1:0]        mode_ctl,
    output logic              mode_ovr,
    output logic [1:0]        idle_lvl,
    output logic [DW-1:0]     rdata
);

    localparam int CTL_LSB = N_OUT;
    localparam int OVR_BIT = N_OUT + 2;

    typedef struct packed {
        logic [N_OUT-1:0] en;
        logic [1:0]       ctl;
        logic             ovr;
        logic [1:0]       idle;
    } regs_t;

    regs_t r_d, r_q;

    logic hit_ctrl, hit_idle, hit_mode, hit_addr;

    assign hit_ctrl = (addr == AW'(RA_CTRL));
    assign hit_idle = (addr == AW'(RA_IDLE));
    assign hit_mode = (addr == AW'(RA_MODE_RB));
    assign hit_addr = (addr == AW'(RA_ADDR_RB));

    always_comb begin
        r_d = r_q;
        if (wr_en && hit_ctrl) begin
            r_d.en  = wdata[N_OUT-1:0];
            r_d.ctl = wdata[CTL_LSB +: 2];
            r_d.ovr = wdata[OVR_BIT];
        end
        if (wr_en && hit_idle) begin
            r_d.idle = wdata[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.en   <= '1;
            r_q.ctl  <= 2'b00;
            r_q.ovr  <= 1'b0;
            r_q.idle <= 2'b00;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_ctrl) begin
            rdata[N_OUT-1:0]    = r_q.en;
            rdata[CTL_LSB +: 2] = r_q.ctl;
            rdata[OVR_BIT]      = r_q.ovr;
        end else if (hit_idle) begin
            rdata[1:0] = r_q.idle;
        end else if (hit_mode) begin
            rdata[1:0] = strap_mode;
        end else if (hit_addr) begin
            rdata[ADDR_W-1:0] = bus_addr;
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    assign out_en   = r_q.en;
    assign mode_ctl = r_q.ctl;
    assign mode_ovr = r_q.ovr;
    assign idle_lvl = r_q.idle;

endmodule

// File: rtl/clkbuf_strap.sv
module clkbuf_strap
    import clkbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic [1:0]        addr_lvl,
    input  logic [1:0]        mode_lvl,
    input  logic [1:0]        mode_ctl,
    input  logic              mode_ovr,
    output logic [ADDR_W-1:0] bus_addr,
    output pll_mode_e         strap_mode,
    output pll_mode_e         mode_eff
);

    typedef struct packed {
        logic              latched;
        logic [ADDR_W-1:0] addr;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (!c_q.latched && pwr_ok) begin
            c_d.latched = 1'b1;
            c_d.addr    = level_to_addr(addr_lvl);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        strap_mode = level_to_mode(mode_lvl);
        mode_eff   = mode_ovr ? level_to_mode(mode_ctl) : strap_mode;
    end

    assign bus_addr = c_q.addr;

endmodule

// File: rtl/clkbuf_lane.sv
module clkbuf_lane (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       ref_in,
    input  logic [1:0] idle_lvl,
    output logic       out_p,
    output logic       out_n
);

    typedef struct packed {
        logic gate;
        logic p;
        logic n;
    } lane_t;

    lane_t l_d, l_q;

    always_comb begin
        l_d      = l_q;
        l_d.gate = ref_in ? l_q.gate : run;
        if (l_d.gate) begin
            l_d.p = ref_in;
            l_d.n = ~ref_in;
        end else begin
            l_d.p = idle_lvl[0];
            l_d.n = idle_lvl[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign out_p = l_q.p;
    assign out_n = l_q.n;

endmodule

// File: rtl/clkbuf_oe_ctrl.sv
module clkbuf_oe_ctrl
    import clkbuf_pkg::*;
#(
    parameter int N_OUT       = 2,
    parameter int DW          = 8,
    parameter int AW          = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic [N_OUT-1:0]  oe_pin_n,
    input  logic [1:0]        addr_lvl,
    input  logic [1:0]        mode_lvl,
    input  logic              pll_lock,
    input  logic              ref_in,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        pll_mode,
    output logic              pll_en,
    output logic [N_OUT-1:0]  dif_p,
    output logic [N_OUT-1:0]  dif_n
);

    localparam int              SW       = N_OUT + 2;
    localparam logic [SW-1:0]   SYNC_RST = {2'b00, {N_OUT{1'b1}}};

    logic [SW-1:0]    sync_in, sync_out;
    logic             pwr_s, lock_s;
    logic [N_OUT-1:0] oe_s;

    logic [N_OUT-1:0] out_en;
    logic [1:0]       mode_ctl, idle_lvl;
    logic             mode_ovr;
    pll_mode_e        strap_mode, mode_eff;

    logic             bypass;
    logic [N_OUT-1:0] run;
    logic [N_OUT-1:0] lane_p, lane_n;

    assign sync_in = {pwr_good, pll_lock, oe_pin_n};

    clkbuf_sync #(
        .W       (SW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (sync_in),
        .q_out (sync_out)
    );

    assign pwr_s  = sync_out[SW-1];
    assign lock_s = sync_out[SW-2];
    assign oe_s   = sync_out[N_OUT-1:0];

    clkbuf_regs #(
        .N_OUT (N_OUT),
        .DW    (DW),
        .AW    (AW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .strap_mode (strap_mode),
        .bus_addr   (bus_addr),
        .out_en     (out_en),
        .mode_ctl   (mode_ctl),
        .mode_ovr   (mode_ovr),
        .idle_lvl   (idle_lvl),
        .rdata      (reg_rdata)
    );

    clkbuf_strap u_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_ok     (pwr_s),
        .addr_lvl   (addr_lvl),
        .mode_lvl   (mode_lvl),
        .mode_ctl   (mode_ctl),
        .mode_ovr   (mode_ovr),
        .bus_addr   (bus_addr),
        .strap_mode (strap_mode),
        .mode_eff   (mode_eff)
    );

    always_comb begin
        bypass = (mode_eff == PLL_BYPASS);
        for (int i = 0; i < N_OUT; i++) begin
            run[i] = pwr_s && out_en[i] && !oe_s[i] && (bypass || lock_s);
        end
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_lane
        clkbuf_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run[g]),
            .ref_in   (ref_in),
            .idle_lvl (idle_lvl),
            .out_p    (lane_p[g]),
            .out_n    (lane_n[g])
        );
    end

    assign pll_mode = mode_eff;
    assign pll_en   = pwr_good && !bypass;
    assign dif_p    = lane_p & {N_OUT{pwr_good}};
    assign dif_n    = lane_n & {N_OUT{pwr_good}};

endmodule

// File: rtl/clkbuf_oe_ctrl_chk.sv
module clkbuf_oe_ctrl_chk #(
    parameter int N_OUT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_good,
    input logic             pll_en,
    input logic [1:0]       pll_mode,
    input logic [6:0]       bus_addr,
    input logic [N_OUT-1:0] dif_p,
    input logic [N_OUT-1:0] dif_n
);

    p_pd_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |-> (dif_p == '0 && dif_n == '0 && !pll_en));

    p_bypass_pll_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_mode == 2'b01) |-> !pll_en);

    p_mode_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pll_mode != 2'b10);

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != 7'd0) |=> $stable(bus_addr));

    p_addr_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 7'd0) || (bus_addr >= 7'b1101011 && bus_addr <= 7'b1101101));

    p_pll_follows_pwr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en |-> pwr_good);

endmodule

bind clkbuf_oe_ctrl clkbuf_oe_ctrl_chk #(.N_OUT(N_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .pll_en   (pll_en),
    .pll_mode (pll_mode),
    .bus_addr (bus_addr),
    .dif_p    (dif_p),
    .dif_n    (dif_n)
);

// File: tb/clkbuf_oe_ctrl_tb.sv
module clkbuf_oe_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pwr_good;
    logic [1:0] oe_pin_n;
    logic [1:0] addr_lvl, mode_lvl;
    logic       pll_lock;
    logic       ref_in = 1'b0;
    logic       reg_we;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [6:0] bus_addr;
    logic [1:0] pll_mode;
    logic       pll_en;
    logic [1:0] dif_p, dif_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkbuf_oe_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .oe_pin_n(oe_pin_n),
        .addr_lvl(addr_lvl), .mode_lvl(mode_lvl), .pll_lock(pll_lock),
        .ref_in(ref_in), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_addr(bus_addr),
        .pll_mode(pll_mode), .pll_en(pll_en), .dif_p(dif_p), .dif_n(dif_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h time=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    function automatic logic [1:0] lvl_mode(input logic [1:0] l);
        if (l == 2'b00) return 2'b00;
        if (l == 2'b11) return 2'b11;
        return 2'b01;
    endfunction

    function automatic logic [6:0] lvl_addr(input logic [1:0] l);
        if (l == 2'b00) return 7'h6B;
        if (l == 2'b11) return 7'h6D;
        return 7'h6C;
    endfunction

    bit       m_pwr[2], m_lock[2];
    bit [1:0] m_oe[2];
    bit [1:0] m_gate, m_p, m_n, m_en, m_ctl, m_idle;
    bit       m_ovr, m_latched;
    bit [6:0] m_addr;

    function automatic logic [1:0] m_mode();
        return m_ovr ? lvl_mode(m_ctl) : lvl_mode(mode_lvl);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pwr = '{0, 0}; m_lock = '{0, 0}; m_oe = '{2'b11, 2'b11};
            m_gate = 0; m_p = 0; m_n = 0; m_en = 2'b11; m_ctl = 0; m_idle = 0;
            m_ovr = 0; m_latched = 0; m_addr = 0;
        end else begin
            bit byp;
            byp = (m_mode() == 2'b01);
            for (int i = 0; i < 2; i++) begin
                bit go;
                go = m_pwr[1] && m_en[i] && !m_oe[1][i] && (byp || m_lock[1]);
                if (!ref_in) m_gate[i] = go;
                m_p[i] = m_gate[i] ? ref_in  : m_idle[0];
                m_n[i] = m_gate[i] ? !ref_in : m_idle[1];
            end
            if (!m_latched && m_pwr[1]) begin
                m_latched = 1; m_addr = lvl_addr(addr_lvl);
            end
            m_pwr[1] = m_pwr[0];   m_pwr[0] = pwr_good;
            m_lock[1] = m_lock[0]; m_lock[0] = pll_lock;
            m_oe[1] = m_oe[0];     m_oe[0] = oe_pin_n;
            if (reg_we && reg_addr == 2'd0) begin
                m_en = reg_wdata[1:0]; m_ctl = reg_wdata[3:2]; m_ovr = reg_wdata[4];
            end
            if (reg_we && reg_addr == 2'd1) m_idle = reg_wdata[1:0];
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] rexp;
            case (reg_addr)
                2'd0:    rexp = {3'b000, m_ovr, m_ctl, m_en};
                2'd1:    rexp = {6'b0, m_idle};
                2'd2:    rexp = {6'b0, lvl_mode(mode_lvl)};
                default: rexp = {1'b0, m_addr};
            endcase
            chk("R8 dif_p model", dif_p, m_p & {2{pwr_good}});
            chk("R8 dif_n model", dif_n, m_n & {2{pwr_good}});
            chk("R5 pll_mode model", pll_mode, m_mode());
            chk("R1 pll_en model", pll_en, pwr_good && m_mode() != 2'b01);
            chk("R7 bus_addr model", bus_addr, m_addr);
            chk("R6 rdata model", reg_rdata, rexp);
        end
    end

    // reference clock: 3 cycles high, 3 low
    initial begin
        int rc = 0;
        forever begin
            @(posedge clk); #2;
            rc = (rc + 1) % 6;
            ref_in = (rc < 3);
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_we = 0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        reg_addr = a; #1;
        chk(tag, reg_rdata, e);
    endtask

    task automatic observe(input string tag, output bit toggled);
        bit hi = 0, lo = 0;
        repeat (12) begin
            @(negedge clk);
            if (dif_p[0]) hi = 1; else lo = 1;
            chk("R8 complement opposite", dif_p[0] ^ dif_n[0], 1);
        end
        toggled = hi && lo;
        chk(tag, toggled, 1);
        step(1);
    endtask

    initial begin
        bit t;
        rst_n = 0; pwr_good = 0; oe_pin_n = 2'b00; addr_lvl = 2'b01; mode_lvl = 2'b11;
        pll_lock = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        step(3); rst_n = 1; step(1);

        rd(2'd0, 8'h03, "R9 ctrl reset");
        rd(2'd1, 8'h00, "R9 idle reset");
        rd(2'd3, 8'h00, "R9 addr before capture");

        step(8);
        chk("R1 dif_p power down", dif_p, 0);
        chk("R1 dif_n power down", dif_n, 0);
        chk("R1 pll_en power down", pll_en, 0);

        pwr_good = 1; step(6);
        chk("R7 addr mid", bus_addr, 7'h6C);
        addr_lvl = 2'b11; step(4);
        chk("R7 addr held", bus_addr, 7'h6C);

        step(8);
        chk("R4 blocked p", dif_p, 0);
        chk("R4 blocked n", dif_n, 0);
        chk("R5 pll on hi bw", pll_en, 1);

        wr(2'd1, 8'h01); step(8);
        chk("R3 idle true high", dif_p, 2'b11);
        chk("R3 idle comp low", dif_n, 2'b00);
        wr(2'd1, 8'h02); step(8);
        chk("R3 idle true low", dif_p, 2'b00);
        chk("R3 idle comp high", dif_n, 2'b11);
        wr(2'd1, 8'h00);

        pll_lock = 1; step(4);
        observe("R4 runs after lock", t);

        oe_pin_n = 2'b10; step(10);
        chk("R2 pin parks out1", {dif_p[1], dif_n[1]}, 0);
        observe("R2 out0 still runs", t);
        oe_pin_n = 2'b00; wr(2'd0, 8'h02); step(10);
        chk("R2 reg bit parks out0", {dif_p[0], dif_n[0]}, 0);
        wr(2'd0, 8'h03);

        pll_lock = 0; mode_lvl = 2'b01; step(10);
        chk("R5 bypass code", pll_mode, 2'b01);
        chk("R5 bypass pll off", pll_en, 0);
        observe("R5 bypass runs without lock", t);
        mode_lvl = 2'b10; step(2);
        chk("R5 level 10 is bypass", pll_mode, 2'b01);
        mode_lvl = 2'b00; step(2);
        chk("R5 low bw code", pll_mode, 2'b00);
        rd(2'd2, 8'h00, "R6 readback low");
        step(10);
        chk("R4 blocked low bw", dif_p, 0);
        mode_lvl = 2'b11;
        rd(2'd2, 8'h03, "R6 readback high");

        wr(2'd0, 8'h17); step(1);
        chk("R6 override bypass", pll_mode, 2'b01);
        chk("R6 override pll off", pll_en, 0);
        rd(2'd0, 8'h17, "R6 ctrl readback");
        rd(2'd2, 8'h03, "R6 strap readback kept");
        wr(2'd0, 8'h1B); step(1);
        chk("R6 ctl 10 as bypass", pll_mode, 2'b01);
        wr(2'd0, 8'h13); step(1);
        chk("R6 ctl low bw", pll_mode, 2'b00);
        wr(2'd0, 8'h03); step(1);
        chk("R6 strap again", pll_mode, 2'b11);
        wr(2'd2, 8'hFF);
        rd(2'd2, 8'h03, "R6 read-only mode");
        wr(2'd3, 8'h00);
        rd(2'd3, 8'h6C, "R6 read-only addr");

        pll_lock = 1; step(6);
        pwr_good = 0; #1;
        chk("R1 immediate low p", dif_p, 0);
        chk("R1 immediate low n", dif_n, 0);
        chk("R1 immediate pll off", pll_en, 0);
        step(6);
        chk("R1 held low", dif_p | dif_n, 0);
        pwr_good = 1; step(10);
        chk("R7 no recapture", bus_addr, 7'h6C);
        observe("R2 runs after power return", t);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule